// File: doc/BRIEF.md
# RF Clock Harmonic Change Tracker

This block watches an RF-derived sampling clock from a fixed reference clock and works out, inside the logic alone, when the RF harmonic number has switched during an accelerator cycle. It counts RF rising edges over a programmable window of reference cycles and publishes that count. When two consecutive window counts differ by more than a programmable threshold, it treats the event as a harmonic change rather than a slow frequency ramp.

Before a cycle starts, software loads a small table with the ordered harmonic numbers the cycle will use. A cycle-start strobe rewinds the table pointer to the first entry. On each detected change the pointer steps to the next entry, and the feedback-loop enable drops for a programmable number of reference cycles so the loop pipeline can be flushed. A change seen on the last entry leaves the pointer in place and raises a sticky overflow flag.

Top module: `rf_harmonic_tracker`

## Requirements
- R1: After reset, harm_idx is 0, harm_val is 0 (all table entries reset to 0), loop_en is 1, seq_ovf is 0 and meas_count is 0.
- R2: At the end of every window of G reference cycles (G = gate length register, address DEPTH), meas_count shows the number of rf_clk rising edges in that window, to within one count.
- R3: A change is detected at a window end when the new count differs from the previous window's count by more than the threshold register (address DEPTH+1). A detected change moves harm_idx up by exactly one. Smaller differences, such as a slow ramp, leave harm_idx unchanged.
- R4: On a detected change with purge length P > 0 (address DEPTH+2), loop_en goes low in the next cycle and stays low for exactly P reference cycles.
- R5: While loop_en is low for a purge, further detections are ignored: harm_idx does not move and the purge is not restarted.
- R6: A detection while harm_idx is at or beyond the last-entry register (address DEPTH+3, values above DEPTH-1 clamp to DEPTH-1) leaves harm_idx unchanged, still starts a purge, and sets seq_ovf. seq_ovf stays set until cycle start or reset.
- R7: A cycle_start pulse, which takes priority over a simultaneous detection, sets harm_idx to 0, clears seq_ovf and ends any purge, so that loop_en is 1 in the next cycle.
- R8: A write with cfg_addr below DEPTH loads that table entry (low HARM_W bits of cfg_wdata). harm_val always equals the entry selected by harm_idx, and it follows a write to that entry in the next cycle.
- R9: With purge length 0, a detected change still advances harm_idx, but loop_en stays 1.
- R10: The first window after reset, and the first window after any write to the gate length register, produce no detection. A gate length write restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fixed reference clock; all control logic runs on it |
| rf_clk | input | 1 | RF-derived clock whose edges are counted |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-cycle strobe marking the start of an accelerator cycle |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | $clog2(DEPTH+4) | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| meas_count | output | 16 | RF edges counted in the last complete window |
| harm_idx | output | $clog2(DEPTH) | Current position in the harmonic table |
| harm_val | output | HARM_W | Harmonic number at the current position |
| loop_en | output | 1 | Feedback loop enable, low while purging |
| seq_ovf | output | 1 | Sticky flag: a change arrived with no table entry left |

## Verification
A step in frequency that falls partway through a window gives an intermediate count. That produces two jumps in a row, so the bench places steps at random points. A design that does not block detections during a purge would then advance the table twice for one change. Slow ramps and a doubling of the gate length are applied on purpose: a design that compares against the threshold wrongly, or keeps its history across a gate change, would step the table falsely. The bench also measures the exact length of each low period of the enable, drives the pointer past the last entry, and strobes cycle start in the middle of a purge. Off-by-one purge counters, pointer wrap-around and a purge that keeps running after cycle start all show up directly at the ports.

// File: rtl/hct_pkg.sv
`timescale 1ns/1ps
package hct_pkg;

  localparam int CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t gray_enc(cnt_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic cnt_t gray_dec(cnt_t g);
    cnt_t b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  function automatic cnt_t abs_diff(cnt_t a, cnt_t b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // last counter value of a window of g cycles; a zero length behaves as one
  function automatic cnt_t last_tick(cnt_t g);
    return (g == '0) ? '0 : (g - 1'b1);
  endfunction

endpackage

// File: rtl/hct_rf_counter.sv
`timescale 1ns/1ps
module hct_rf_counter
  import hct_pkg::*;
(
  input  logic rf_clk,
  input  logic rst_n,
  output cnt_t rf_gray_o
);

  logic [1:0] rst_pipe;
  logic       rf_rst_n;
  cnt_t       edge_cnt;
  cnt_t       edge_nxt;

  always_ff @(posedge rf_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rf_rst_n = rst_pipe[1];
  assign edge_nxt = edge_cnt + 1'b1;

  // registered gray copy: one bit flips per rf edge, so any sample is coherent
  always_ff @(posedge rf_clk or negedge rf_rst_n) begin
    if (!rf_rst_n) begin
      edge_cnt  <= '0;
      rf_gray_o <= '0;
    end else begin
      edge_cnt  <= edge_nxt;
      rf_gray_o <= gray_enc(edge_nxt);
    end
  end

endmodule

// File: rtl/hct_meter.sv
`timescale 1ns/1ps
module hct_meter
  import hct_pkg::*;
(
  input  logic ref_clk,
  input  logic rst_n,
  input  cnt_t rf_gray_i,
  input  cnt_t gate_len,
  input  cnt_t thresh,
  input  logic restart,
  output cnt_t meas_o,
  output logic jump_o
);

  cnt_t sync1, sync2;
  cnt_t now_bin;
  cnt_t snap;
  cnt_t gate_cnt;
  cnt_t fresh;
  logic meas_ok;
  logic win_end;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= rf_gray_i;
      sync2 <= sync1;
    end
  end

  assign now_bin = gray_dec(sync2);
  assign fresh   = now_bin - snap;
  assign win_end = (gate_cnt >= last_tick(gate_len));
  assign jump_o  = !restart && win_end && meas_ok &&
                   (abs_diff(fresh, meas_o) > thresh);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_cnt <= '0;
      snap     <= '0;
      meas_o   <= '0;
      meas_ok  <= 1'b0;
    end else if (restart) begin
      gate_cnt <= '0;
      snap     <= now_bin;
      meas_ok  <= 1'b0;
    end else if (win_end) begin
      gate_cnt <= '0;
      snap     <= now_bin;
      meas_o   <= fresh;
      meas_ok  <= 1'b1;
    end else begin
      gate_cnt <= gate_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/hct_cfg_regs.sv
`timescale 1ns/1ps
module hct_cfg_regs
  import hct_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int HARM_W    = 8,
  parameter int GATE_DEF  = 64,
  parameter int THR_DEF   = 8,
  parameter int PURGE_DEF = 192,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int AW       = $clog2(DEPTH + 4)
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  cnt_t              cfg_wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HARM_W-1:0] harm_val_o,
  output cnt_t              gate_len,
  output cnt_t              thresh,
  output cnt_t              purge_len,
  output logic [IDX_W-1:0]  last_idx,
  output logic              gate_wr
);

  localparam int ADDR_GATE  = DEPTH;
  localparam int ADDR_THR   = DEPTH + 1;
  localparam int ADDR_PURGE = DEPTH + 2;
  localparam int ADDR_LAST  = DEPTH + 3;

  logic [HARM_W-1:0] table_q [DEPTH];
  logic [IDX_W-1:0]  last_wr;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) table_q[e] <= '0;
      else if (cfg_we && cfg_addr == AW'(e)) table_q[e] <= cfg_wdata[HARM_W-1:0];
    end
  end

  assign harm_val_o = table_q[rd_idx];
  assign gate_wr    = cfg_we && (cfg_addr == AW'(ADDR_GATE));
  assign last_wr    = (cfg_wdata >= cnt_t'(DEPTH)) ? IDX_W'(DEPTH - 1)
                                                   : cfg_wdata[IDX_W-1:0];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_len  <= cnt_t'(GATE_DEF);
      thresh    <= cnt_t'(THR_DEF);
      purge_len <= cnt_t'(PURGE_DEF);
      last_idx  <= IDX_W'(DEPTH - 1);
    end else if (cfg_we) begin
      if (cfg_addr == AW'(ADDR_GATE))  gate_len  <= cfg_wdata;
      if (cfg_addr == AW'(ADDR_THR))   thresh    <= cfg_wdata;
      if (cfg_addr == AW'(ADDR_PURGE)) purge_len <= cfg_wdata;
      if (cfg_addr == AW'(ADDR_LAST))  last_idx  <= last_wr;
    end
  end

endmodule

// File: rtl/hct_sequencer.sv
`timescale 1ns/1ps
module hct_sequencer
  import hct_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             jump_i,
  input  cnt_t             purge_len,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] idx_o,
  output logic             loop_en_o,
  output logic             ovf_o
);

  cnt_t purge_cnt;
  logic purging;
  logic take_jump;

  function automatic logic at_end(logic [IDX_W-1:0] i, logic [IDX_W-1:0] last);
    return i >= last;
  endfunction

  assign purging   = (purge_cnt != '0);
  assign take_jump = jump_i && !purging;
  assign loop_en_o = !purging;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_o     <= '0;
      purge_cnt <= '0;
      ovf_o     <= 1'b0;
    end else if (cyc_start) begin
      idx_o     <= '0;
      purge_cnt <= '0;
      ovf_o     <= 1'b0;
    end else if (take_jump) begin
      purge_cnt <= purge_len;
      if (at_end(idx_o, last_idx)) ovf_o <= 1'b1;
      else                         idx_o <= idx_o + 1'b1;
    end else if (purging) begin
      purge_cnt <= purge_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/rf_harmonic_tracker.sv
`timescale 1ns/1ps
module rf_harmonic_tracker
  import hct_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int HARM_W    = 8,
  parameter int GATE_DEF  = 64,
  parameter int THR_DEF   = 8,
  parameter int PURGE_DEF = 192,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int AW       = $clog2(DEPTH + 4)
) (
  input  logic              ref_clk,
  input  logic              rf_clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  output logic [CNT_W-1:0]  meas_count,
  output logic [IDX_W-1:0]  harm_idx,
  output logic [HARM_W-1:0] harm_val,
  output logic              loop_en,
  output logic              seq_ovf
);

  cnt_t             rf_gray;
  cnt_t             gate_len;
  cnt_t             thresh;
  cnt_t             purge_len;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] idx;
  logic             gate_wr;
  logic             jump_evt;

  hct_rf_counter u_rf_cnt (
    .rf_clk    (rf_clk),
    .rst_n     (rst_n),
    .rf_gray_o (rf_gray)
  );

  hct_meter u_meter (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .rf_gray_i (rf_gray),
    .gate_len  (gate_len),
    .thresh    (thresh),
    .restart   (gate_wr),
    .meas_o    (meas_count),
    .jump_o    (jump_evt)
  );

  hct_cfg_regs #(
    .DEPTH     (DEPTH),
    .HARM_W    (HARM_W),
    .GATE_DEF  (GATE_DEF),
    .THR_DEF   (THR_DEF),
    .PURGE_DEF (PURGE_DEF)
  ) u_regs (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .rd_idx     (idx),
    .harm_val_o (harm_val),
    .gate_len   (gate_len),
    .thresh     (thresh),
    .purge_len  (purge_len),
    .last_idx   (last_idx),
    .gate_wr    (gate_wr)
  );

  hct_sequencer #(
    .DEPTH (DEPTH)
  ) u_seq (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .jump_i    (jump_evt),
    .purge_len (purge_len),
    .last_idx  (last_idx),
    .idx_o     (idx),
    .loop_en_o (loop_en),
    .ovf_o     (seq_ovf)
  );

  assign harm_idx = idx;

endmodule

// File: rtl/hct_checks.sv
`timescale 1ns/1ps
module hct_checks
  import hct_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input logic             ref_clk,
  input logic             rst_n,
  input logic             cyc_start,
  input logic             jump_evt,
  input cnt_t             purge_len,
  input logic             loop_en,
  input logic [IDX_W-1:0] harm_idx,
  input logic             seq_ovf
);

  a_r3_idx_needs_jump: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!cyc_start && !jump_evt) |=> $stable(harm_idx));

  a_r3_idx_single_step: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !cyc_start |=> (harm_idx == $past(harm_idx) || harm_idx == $past(harm_idx) + 1'b1));

  a_r4_purge_starts: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (jump_evt && loop_en && !cyc_start && purge_len != '0) |=> !loop_en);

  a_r5_idx_frozen_in_purge: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!loop_en && !cyc_start) |=> $stable(harm_idx));

  a_r6_ovf_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (seq_ovf && !cyc_start) |=> seq_ovf);

  a_r7_start_clears: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cyc_start |=> (harm_idx == '0 && !seq_ovf && loop_en));

  a_r9_no_purge_at_zero: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (purge_len == '0 && loop_en && !cyc_start) |=> loop_en);

endmodule

bind rf_harmonic_tracker hct_checks #(.IDX_W(IDX_W)) u_checks (
  .ref_clk   (ref_clk),
  .rst_n     (rst_n),
  .cyc_start (cyc_start),
  .jump_evt  (jump_evt),
  .purge_len (purge_len),
  .loop_en   (loop_en),
  .harm_idx  (harm_idx),
  .seq_ovf   (seq_ovf)
);

// File: tb/rf_harmonic_tracker_tb.sv
`timescale 1ns/1ps
module rf_harmonic_tracker_tb;

  localparam int DEPTH  = 8;
  localparam int HARM_W = 8;
  localparam int IDX_W  = 3;
  localparam int AW     = 4;
  localparam int A_GATE = DEPTH;
  localparam int A_THR  = DEPTH + 1;
  localparam int A_PRG  = DEPTH + 2;
  localparam int A_LAST = DEPTH + 3;

  logic ref_clk = 1'b0, rf_clk = 1'b0, rst_n = 1'b0;
  logic cyc_start = 1'b0, cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   meas_count;
  logic [IDX_W-1:0]  harm_idx;
  logic [HARM_W-1:0] harm_val;
  logic loop_en, seq_ovf;

  int rf_half_ps = 5000;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int gate = 64, thr = 8, purge = 200, last = 7;
  int eidx = 0;
  bit eovf = 1'b0;
  logic [HARM_W-1:0] tbl [DEPTH];
  int low_run = 0, last_run = 0, n_runs = 0;

  rf_harmonic_tracker u_dut (
    .ref_clk(ref_clk), .rf_clk(rf_clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .meas_count(meas_count), .harm_idx(harm_idx), .harm_val(harm_val),
    .loop_en(loop_en), .seq_ovf(seq_ovf)
  );

  always #4 ref_clk = ~ref_clk;
  initial forever #(rf_half_ps / 1000.0) rf_clk = ~rf_clk;

  // length of every low period of the loop enable
  always @(negedge ref_clk) begin
    if (rst_n) begin
      if (!loop_en) low_run++;
      else if (low_run != 0) begin
        last_run = low_run;
        n_runs++;
        low_run = 0;
      end
    end
  end

  function automatic int exp_cnt(int g, int hps);
    return (g * 4000) / hps;
  endfunction

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic bit near(int a, int e);
    return (a >= e - 1) && (a <= e + 1);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic cfg(int a, int d);
    @(negedge ref_clk);
    cfg_we = 1'b1; cfg_addr = a[AW-1:0]; cfg_wdata = d[15:0];
    @(negedge ref_clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge ref_clk);
    cyc_start = 1'b1;
    @(negedge ref_clk);
    cyc_start = 1'b0;
  endtask

  task automatic model_jump();
    if (eidx >= last) eovf = 1'b1;
    else eidx++;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    int runs0;
    int waited;
    void'($urandom(32'd4711));
    tick(3);
    rst_n = 1'b1;
    @(negedge ref_clk);
    // R1 reset state
    check(harm_idx == 0, "R1 idx", harm_idx, 0);
    check(harm_val == 0, "R1 val", harm_val, 0);
    check(loop_en == 1'b1, "R1 loop_en", loop_en, 1);
    check(seq_ovf == 1'b0, "R1 ovf", seq_ovf, 0);
    check(meas_count == 0, "R1 meas", meas_count, 0);

    for (int i = 0; i < DEPTH; i++) begin
      tbl[i] = HARM_W'($urandom % 200 + 1);
      cfg(i, tbl[i]);
    end
    cfg(A_THR, thr);
    cfg(A_PRG, purge);
    cfg(A_LAST, last);
    cfg(A_GATE, gate);
    check(harm_val == tbl[0], "R8 entry0", harm_val, tbl[0]);

    pulse_start();
    tick(300);
    check(near(meas_count, exp_cnt(gate, rf_half_ps)), "R2 meas 100MHz", meas_count, exp_cnt(gate, rf_half_ps));
    check(harm_idx == 0 && n_runs == 0, "R10 no start-up detection", harm_idx, 0);

    // slow ramp
    rf_half_ps = 5100; tick(200);
    rf_half_ps = 5200; tick(200);
    rf_half_ps = 5300; tick(200);
    check(harm_idx == 0, "R3 ramp ignored", harm_idx, 0);
    check(n_runs == 0, "R3 ramp no purge", n_runs, 0);

    // big step
    rf_half_ps = 10000; tick(400);
    check(harm_idx == 1, "R3 step idx", harm_idx, 1);
    check(harm_val == tbl[1], "R8 step val", harm_val, tbl[1]);
    check(n_runs == 1, "R4 purge count", n_runs, 1);
    check(last_run == purge, "R4 purge length", last_run, purge);
    check(near(meas_count, exp_cnt(gate, 10000)), "R2 meas 50MHz", meas_count, exp_cnt(gate, 10000));

    // double step inside a long purge
    cfg(A_PRG, 600);
    rf_half_ps = 5000; tick(130);
    rf_half_ps = 10000; tick(900);
    check(harm_idx == 2, "R5 one step only", harm_idx, 2);
    check(n_runs == 2, "R5 one purge only", n_runs, 2);
    check(last_run == 600, "R5 purge not restarted", last_run, 600);
    cfg(A_PRG, purge);

    // gate length change
    cfg(A_GATE, 128);
    tick(520);
    check(harm_idx == 2, "R10 gate change no detect", harm_idx, 2);
    check(near(meas_count, exp_cnt(128, 10000)), "R2 meas gate128", meas_count, exp_cnt(128, 10000));
    cfg(A_GATE, gate);
    tick(300);
    check(harm_idx == 2, "R10 gate restore no detect", harm_idx, 2);

    // live table write
    tbl[2] = 8'hA5;
    cfg(2, tbl[2]);
    check(harm_val == 8'hA5, "R8 live write", harm_val, 8'hA5);

    // constrained random steps
    pulse_start();
    eidx = 0; eovf = 1'b0;
    for (int k = 0; k < 10; k++) begin
      int cur, nh, nc, d;
      cur = exp_cnt(gate, rf_half_ps);
      do begin
        nh = 4000 + int'($urandom % 16001);
        nc = exp_cnt(gate, nh);
        d  = absd(nc, cur);
      end while (!(d <= thr - 3 || d >= 2 * thr + 3));
      rf_half_ps = nh;
      if (d >= 2 * thr + 3) model_jump();
      tick(384);
      check(harm_idx == eidx, "R3 random idx", harm_idx, eidx);
      check(seq_ovf == eovf, "R6 random ovf", seq_ovf, eovf);
      check(harm_val == tbl[eidx], "R8 random val", harm_val, tbl[eidx]);
      check(near(meas_count, nc), "R2 random meas", meas_count, nc);
    end

    // overflow on the last entry
    last = 1;
    cfg(A_LAST, last);
    rf_half_ps = 5000; tick(400);
    pulse_start();
    rf_half_ps = 12000; tick(400);
    check(harm_idx == 1, "R6 reach last", harm_idx, 1);
    runs0 = n_runs;
    rf_half_ps = 5000; tick(400);
    check(harm_idx == 1, "R6 idx held", harm_idx, 1);
    check(seq_ovf == 1'b1, "R6 ovf set", seq_ovf, 1);
    check(n_runs == runs0 + 1 && last_run == purge, "R6 purge on overflow", last_run, purge);
    rf_half_ps = 12000; tick(400);
    check(seq_ovf == 1'b1 && harm_idx == 1, "R6 ovf sticky", seq_ovf, 1);

    // cycle start in the middle of a purge
    rf_half_ps = 5000;
    waited = 0;
    while (loop_en && waited < 400) begin
      @(negedge ref_clk);
      waited++;
    end
    check(loop_en == 1'b0, "R7 purge began", loop_en, 0);
    tick(140);
    pulse_start();
    check(loop_en == 1'b1, "R7 enable restored", loop_en, 1);
    check(harm_idx == 0, "R7 idx rewound", harm_idx, 0);
    check(seq_ovf == 1'b0, "R7 ovf cleared", seq_ovf, 0);
    tick(300);
    check(harm_idx == 0, "R7 no stray step", harm_idx, 0);

    // zero purge length
    cfg(A_PRG, 0);
    tick(5);
    runs0 = n_runs;
    rf_half_ps = 12000; tick(400);
    check(harm_idx == 1, "R9 idx advances", harm_idx, 1);
    check(n_runs == runs0 && loop_en == 1'b1, "R9 loop stays on", n_runs, runs0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule